// File: doc/BRIEF.md
# Subset-Partitioned Register Rename Unit

This unit renames a group of four instructions per clock for an out-of-order core. The core's physical registers are divided into four disjoint write subsets, and each execution cluster may only write the subset it owns. Cluster steering happens before renaming, so every instruction arrives with a two-bit subset tag that fixes where its result must live. The unit counts how many destinations each subset needs in the group. It pops exactly that many tags from that subset's own free list, so none is taken and then handed back.

Sources are resolved in program order inside the group. A source whose architectural register is written by an earlier instruction of the same group gets that instruction's fresh tag. Any other source reads the map table as it stood before the group. The map table then keeps, for each architectural register, the tag of the last instruction in the group that writes it. If any subset cannot cover its demand, the group is held back whole. Retired registers come back through one push port per subset. With round-robin steering the per-subset demand is constant, which makes the stall rule trivial. Any subset mix is accepted, though, including a whole group aimed at one subset.

The architectural register count must not exceed the registers in one subset, because reset maps architectural register r to physical tag r, and those tags all fall in subset 0.

Top module: `wsr_rename`

## Requirements
- R1: While reset is held and after it is released, `out_valid` and `stall` are low. The map table starts with architectural register r mapped to tag r.
- R2: A physical tag is 8 bits. Bits 7:6 hold the subset number and bits 5:0 hold the index within the subset. Every destination tag carries the subset given for its lane in `dst_sub`, where lane i uses bits 2i+1:2i.
- R3: Each subset hands out indices in first-in first-out order. After reset, subset 0 holds indices 32..63 and subsets 1..3 hold indices 0..63, each in ascending order. Lanes of one group that share a subset take consecutive entries in lane order, and no two destinations of a group are equal.
- R4: A source of lane i that names the destination register of an earlier lane j<i in the same group receives the new tag of the highest such j.
- R5: A source with no earlier writer in its group receives the map-table entry left by the previous accepted groups.
- R6: After an accepted group, each architectural register written by the group maps to the tag of the last lane that writes it. All other entries are unchanged.
- R7: `stall` is raised in the same cycle as `grp_valid` whenever some subset holds fewer free entries than the group needs from it. A stalled group allocates nothing, leaves the map table untouched and produces no output.
- R8: A tag pushed on a subset's release port joins the tail of that subset's list at the clock edge. It becomes available from the next cycle. A push and pops on the same list in one cycle both take effect.
- R9: The renamed tags and `out_valid` appear on the clock edge that accepts a group, so they are visible for exactly one cycle after the group is presented. `out_valid` is low after cycles with no accepted group.
- R10: A group whose four lanes all name the same subset is accepted when that subset holds at least four free entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | 1 | A rename group is presented |
| src_a_arch | input | 20 | First source architectural register, 5 bits per lane |
| src_b_arch | input | 20 | Second source architectural register, 5 bits per lane |
| dst_arch | input | 20 | Destination architectural register, 5 bits per lane |
| dst_sub | input | 8 | Destination write subset, 2 bits per lane |
| rel_valid | input | 4 | Release push strobe, one bit per subset |
| rel_idx | input | 24 | Released index, 6 bits per subset |
| stall | output | 1 | Presented group cannot be served this cycle |
| out_valid | output | 1 | Renamed group present on the tag outputs |
| src_a_tag | output | 32 | First source physical tag, 8 bits per lane |
| src_b_tag | output | 32 | Second source physical tag, 8 bits per lane |
| dst_tag | output | 32 | New destination physical tag, 8 bits per lane |

## Verification
A corrupted free-list pointer or count shows up one cycle after the next accepted group. It appears either as a destination index out of the expected order or as a stall raised or missed against the model's free counts. A wrong map-table entry stays hidden until a later group reads that register through a source with no in-group producer, so the random groups reread a small set of registers often. Forwarding mistakes appear on the very next output whenever lanes share architectural registers. Narrow destination ranges make that happen in many groups.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  // Default geometry of the rename unit
  parameter int LANES_D     = 4;
  parameter int NSUB_D      = 4;
  parameter int AREGS_D     = 32;
  parameter int SUB_DEPTH_D = 64;
endpackage

// File: rtl/wsr_freelist.sv
// Circular list of free indices for one write subset: up to LANES pops and one push per cycle.
module wsr_freelist #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  parameter int RESV  = 0,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NW-1:0]     pop_n,
  input  logic              push_v,
  input  logic [IW-1:0]     push_idx,
  output logic [CW-1:0]     avail,
  output logic [LANES*IW-1:0] head_idx
);
  logic [IW-1:0] mem [DEPTH];
  logic [IW-1:0] head, tail;
  logic [CW-1:0] cnt;

  for (genvar k = 0; k < LANES; k++) begin : g_rd
    assign head_idx[k*IW +: IW] = mem[head + IW'(k)];
  end

  assign avail = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= IW'(j + RESV);
      head <= '0;
      tail <= IW'(DEPTH - RESV);
      cnt  <= CW'(DEPTH - RESV);
    end else begin
      if (push_v) mem[tail] <= push_idx;
      tail <= tail + IW'(push_v);
      head <= head + IW'(pop_n);
      cnt  <= cnt + CW'(push_v) - CW'(pop_n);
    end
  end
endmodule

// File: rtl/wsr_demand.sv
// Per-subset demand of a group and the rank of each lane inside its subset.
module wsr_demand #(
  parameter int LANES = 4,
  parameter int NSUB  = 4,
  localparam int SW = $clog2(NSUB),
  localparam int NW = $clog2(LANES + 1),
  localparam int RW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES*SW-1:0] sub_flat,
  output logic [NSUB*NW-1:0]  need_flat,
  output logic [LANES*RW-1:0] rank_flat
);
  logic [NW-1:0] tally [NSUB];

  always_comb begin
    for (int s = 0; s < NSUB; s++) tally[s] = '0;
    rank_flat = '0;
    for (int i = 0; i < LANES; i++) begin
      rank_flat[i*RW +: RW] = RW'(tally[sub_flat[i*SW +: SW]]);
      tally[sub_flat[i*SW +: SW]] = tally[sub_flat[i*SW +: SW]] + NW'(1);
    end
    for (int s = 0; s < NSUB; s++) need_flat[s*NW +: NW] = tally[s];
  end
endmodule

// File: rtl/wsr_map_table.sv
// Architectural-to-physical map; later write ports win on the same entry.
module wsr_map_table #(
  parameter int AREGS = 32,
  parameter int TW    = 8,
  parameter int NRD   = 8,
  parameter int NWR   = 4,
  localparam int AW = $clog2(AREGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NRD*AW-1:0]  rd_addr,
  output logic [NRD*TW-1:0]  rd_data,
  input  logic [NWR-1:0]     wr_en,
  input  logic [NWR*AW-1:0]  wr_addr,
  input  logic [NWR*TW-1:0]  wr_data
);
  logic [TW-1:0] map [AREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < AREGS; r++) map[r] <= TW'(r);
    end else begin
      for (int w = 0; w < NWR; w++)
        if (wr_en[w]) map[wr_addr[w*AW +: AW]] <= wr_data[w*TW +: TW];
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p*TW +: TW] = map[rd_addr[p*AW +: AW]];
  end
endmodule

// File: rtl/wsr_rename.sv
module wsr_rename #(
  parameter int LANES     = wsr_pkg::LANES_D,
  parameter int NSUB      = wsr_pkg::NSUB_D,
  parameter int AREGS     = wsr_pkg::AREGS_D,
  parameter int SUB_DEPTH = wsr_pkg::SUB_DEPTH_D,
  localparam int AW = $clog2(AREGS),
  localparam int SW = $clog2(NSUB),
  localparam int IW = $clog2(SUB_DEPTH),
  localparam int TW = SW + IW,
  localparam int CW = $clog2(SUB_DEPTH + 1),
  localparam int NW = $clog2(LANES + 1),
  localparam int RW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                grp_valid,
  input  logic [LANES*AW-1:0] src_a_arch,
  input  logic [LANES*AW-1:0] src_b_arch,
  input  logic [LANES*AW-1:0] dst_arch,
  input  logic [LANES*SW-1:0] dst_sub,
  input  logic [NSUB-1:0]     rel_valid,
  input  logic [NSUB*IW-1:0]  rel_idx,
  output logic                stall,
  output logic                out_valid,
  output logic [LANES*TW-1:0] src_a_tag,
  output logic [LANES*TW-1:0] src_b_tag,
  output logic [LANES*TW-1:0] dst_tag
);
  logic [NSUB*NW-1:0]  need_flat;
  logic [LANES*RW-1:0] rank_flat;
  logic [NSUB-1:0]     short_s;
  logic                accept;
  logic [CW-1:0]       avail [NSUB];
  logic [LANES*IW-1:0] heads_flat [NSUB];
  logic [IW-1:0]       heads [NSUB][LANES];
  logic [TW-1:0]       new_tag [LANES];
  logic [LANES*TW-1:0] new_flat;
  logic [2*LANES*AW-1:0] rd_addr;
  logic [2*LANES*TW-1:0] rd_data;
  logic [LANES*TW-1:0] fwd_a, fwd_b;

  wsr_demand #(.LANES(LANES), .NSUB(NSUB)) u_demand (
    .sub_flat(dst_sub), .need_flat(need_flat), .rank_flat(rank_flat)
  );

  for (genvar s = 0; s < NSUB; s++) begin : g_sub
    logic [NW-1:0] need_s;
    assign need_s     = need_flat[s*NW +: NW];
    assign short_s[s] = avail[s] < CW'(need_s);

    wsr_freelist #(
      .DEPTH(SUB_DEPTH), .LANES(LANES), .RESV((s == 0) ? AREGS : 0)
    ) u_fl (
      .clk(clk), .rst(rst),
      .pop_n(accept ? need_s : '0),
      .push_v(rel_valid[s]),
      .push_idx(rel_idx[s*IW +: IW]),
      .avail(avail[s]),
      .head_idx(heads_flat[s])
    );

    for (genvar k = 0; k < LANES; k++) begin : g_head
      assign heads[s][k] = heads_flat[s][k*IW +: IW];
    end
  end

  assign stall  = grp_valid & (|short_s);
  assign accept = grp_valid & ~(|short_s);

  // New destination tag: lane's subset plus the entry matching its rank in that subset
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      new_tag[i] = {dst_sub[i*SW +: SW],
                    heads[dst_sub[i*SW +: SW]][rank_flat[i*RW +: RW]]};
      new_flat[i*TW +: TW] = new_tag[i];
    end
  end

  assign rd_addr = {src_b_arch, src_a_arch};

  wsr_map_table #(.AREGS(AREGS), .TW(TW), .NRD(2*LANES), .NWR(LANES)) u_map (
    .clk(clk), .rst(rst),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en({LANES{accept}}), .wr_addr(dst_arch), .wr_data(new_flat)
  );

  // In-group dependency resolution: latest earlier writer overrides the map
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      fwd_a[i*TW +: TW] = rd_data[i*TW +: TW];
      fwd_b[i*TW +: TW] = rd_data[(LANES+i)*TW +: TW];
      for (int j = 0; j < i; j++) begin
        if (dst_arch[j*AW +: AW] == src_a_arch[i*AW +: AW]) fwd_a[i*TW +: TW] = new_tag[j];
        if (dst_arch[j*AW +: AW] == src_b_arch[i*AW +: AW]) fwd_b[i*TW +: TW] = new_tag[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      src_a_tag <= '0;
      src_b_tag <= '0;
      dst_tag   <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        src_a_tag <= fwd_a;
        src_b_tag <= fwd_b;
        dst_tag   <= new_flat;
      end
    end
  end
endmodule

// File: rtl/wsr_rename_chk.sv
module wsr_rename_chk #(
  parameter int LANES = 4,
  parameter int AW    = 5,
  parameter int SW    = 2,
  parameter int TW    = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                grp_valid,
  input logic                stall,
  input logic                out_valid,
  input logic [LANES*AW-1:0] src_a_arch,
  input logic [LANES*AW-1:0] dst_arch,
  input logic [LANES*SW-1:0] dst_sub,
  input logic [LANES*TW-1:0] src_a_tag,
  input logic [LANES*TW-1:0] dst_tag
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R7
  stall_needs_group_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> grp_valid);

  // R7
  stall_no_output_chk: assert property (@(posedge clk) disable iff (rst)
    (!grp_valid || stall) |=> !out_valid);

  // R9
  accept_output_chk: assert property (@(posedge clk) disable iff (rst)
    (grp_valid && !stall) |=> out_valid);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // R2
    dst_subset_chk: assert property (@(posedge clk) disable iff (rst)
      (grp_valid && !stall) |=>
        (dst_tag[i*TW + TW - SW +: SW] == $past(dst_sub[i*SW +: SW])));

    for (genvar j = i + 1; j < LANES; j++) begin : g_pair
      // R3
      dst_unique_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (dst_tag[i*TW +: TW] != dst_tag[j*TW +: TW]));
    end

    if (i > 0) begin : g_fwd
      // R4
      fwd_prev_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (grp_valid && !stall &&
         dst_arch[(i-1)*AW +: AW] == src_a_arch[i*AW +: AW]) |=>
          (src_a_tag[i*TW +: TW] == dst_tag[(i-1)*TW +: TW]));
    end
  end
endmodule

bind wsr_rename wsr_rename_chk #(.LANES(LANES), .AW(AW), .SW(SW), .TW(TW)) u_chk (.*);

// File: tb/sim_wsr_rename.sv
`timescale 1ns/1ps
module sim_wsr_rename;
  localparam int LANES = 4, NSUB = 4, AREGS = 32, AW = 5, SW = 2, IW = 6, TW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic                grp_valid = 1'b0;
  logic [LANES*AW-1:0] src_a_arch = '0, src_b_arch = '0, dst_arch = '0;
  logic [LANES*SW-1:0] dst_sub = '0;
  logic [NSUB-1:0]     rel_valid = '0;
  logic [NSUB*IW-1:0]  rel_idx = '0;
  logic                stall, out_valid;
  logic [LANES*TW-1:0] src_a_tag, src_b_tag, dst_tag;

  wsr_rename u0 (
    .clk(clk), .rst(rst), .grp_valid(grp_valid),
    .src_a_arch(src_a_arch), .src_b_arch(src_b_arch), .dst_arch(dst_arch),
    .dst_sub(dst_sub), .rel_valid(rel_valid), .rel_idx(rel_idx),
    .stall(stall), .out_valid(out_valid),
    .src_a_tag(src_a_tag), .src_b_tag(src_b_tag), .dst_tag(dst_tag)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Behavioural model state
  int mm [AREGS];
  int fq [NSUB][$];
  int rq [NSUB][$];

  typedef struct packed {
    logic        v;
    logic [31:0] a, b, d;
    logic [3:0]  af, bf;
  } exp_t;
  exp_t  sbq [$];
  string lblq [$];
  exp_t  cur;
  string cur_lbl;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Monitor: pops one expectation per cycle
  always @(negedge clk) begin
    if (!rst && sbq.size() > 0) begin
      cur = sbq.pop_front();
      cur_lbl = lblq.pop_front();
      chk(out_valid == cur.v, "R9", "out_valid", int'(out_valid), int'(cur.v));
      if (cur.v) begin
        for (int i = 0; i < LANES; i++) begin
          chk(dst_tag[i*TW +: TW] == cur.d[i*8 +: 8], "R3", $sformatf("lane%0d dst", i),
              int'(dst_tag[i*TW +: TW]), int'(cur.d[i*8 +: 8]));
          chk(dst_tag[i*TW+IW +: SW] == cur.d[i*8+6 +: 2], "R2", $sformatf("lane%0d subset", i),
              int'(dst_tag[i*TW+IW +: SW]), int'(cur.d[i*8+6 +: 2]));
          chk(src_a_tag[i*TW +: TW] == cur.a[i*8 +: 8], cur.af[i] ? "R4" : cur_lbl,
              $sformatf("lane%0d srcA", i), int'(src_a_tag[i*TW +: TW]), int'(cur.a[i*8 +: 8]));
          chk(src_b_tag[i*TW +: TW] == cur.b[i*8 +: 8], cur.bf[i] ? "R4" : cur_lbl,
              $sformatf("lane%0d srcB", i), int'(src_b_tag[i*TW +: TW]), int'(cur.b[i*8 +: 8]));
        end
      end
    end
  end

  // Driver: presents one group (or idle cycle) and records the expected result
  task automatic run_group(input bit gv, input logic [19:0] sa, input logic [19:0] sb,
                           input logic [19:0] da, input logic [7:0] sdv, input logic [3:0] relm,
                           input string lbl_stall, input string lbl_map);
    int    pick [NSUB];
    int    need [NSUB];
    bit    exp_st;
    exp_t  e;
    @(negedge clk);
    grp_valid  = gv;
    src_a_arch = sa;
    src_b_arch = sb;
    dst_arch   = da;
    dst_sub    = sdv;
    for (int s = 0; s < NSUB; s++) begin
      need[s] = 0;
      pick[s] = 0;
      if (relm[s] && rq[s].size() > 0) begin
        pick[s] = rq[s].pop_front();
        rel_valid[s] = 1'b1;
        rel_idx[s*IW +: IW] = IW'(pick[s]);
      end else begin
        rel_valid[s] = 1'b0;
      end
    end
    for (int i = 0; i < LANES; i++) need[sdv[i*2 +: 2]]++;
    exp_st = 1'b0;
    if (gv) for (int s = 0; s < NSUB; s++) if (fq[s].size() < need[s]) exp_st = 1'b1;
    #1;
    chk(stall == exp_st, lbl_stall, "stall", int'(stall), int'(exp_st));
    e = '0;
    e.v = gv && !exp_st;
    if (e.v) begin
      for (int i = 0; i < LANES; i++) begin
        int s, nt, old, ra, rb, rd;
        ra = int'(sa[i*5 +: 5]);
        rb = int'(sb[i*5 +: 5]);
        rd = int'(da[i*5 +: 5]);
        s  = int'(sdv[i*2 +: 2]);
        for (int j = 0; j < i; j++) begin
          if (da[j*5 +: 5] == sa[i*5 +: 5]) e.af[i] = 1'b1;
          if (da[j*5 +: 5] == sb[i*5 +: 5]) e.bf[i] = 1'b1;
        end
        e.a[i*8 +: 8] = 8'(mm[ra]);
        e.b[i*8 +: 8] = 8'(mm[rb]);
        nt  = s * 64 + fq[s].pop_front();
        old = mm[rd];
        rq[old / 64].push_back(old % 64);
        mm[rd] = nt;
        e.d[i*8 +: 8] = 8'(nt);
      end
    end
    for (int s = 0; s < NSUB; s++) if (rel_valid[s]) fq[s].push_back(pick[s]);
    sbq.push_back(e);
    lblq.push_back(lbl_map);
  endtask

  initial begin
    logic [19:0] sa, sb, da;
    logic [7:0]  sdv;
    logic [1:0]  one;
    for (int r = 0; r < AREGS; r++) mm[r] = r;
    for (int k = 32; k < 64; k++) fq[0].push_back(k);
    for (int s = 1; s < NSUB; s++) for (int k = 0; k < 64; k++) fq[s].push_back(k);

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(stall == 1'b0, "R1", "stall after reset", int'(stall), 0);

    // Whole groups aimed at subset 3 until it runs dry (first group reads reset map)
    for (int g = 0; g < 16; g++) begin
      sa = 20'($urandom);
      sb = 20'($urandom);
      for (int i = 0; i < LANES; i++) da[i*5 +: 5] = 5'((g*4 + i) % 32);
      run_group(1'b1, sa, sb, da, 8'hFF, 4'b0000, "R10", (g == 0) ? "R1" : "R5");
    end
    run_group(1'b1, 20'h12345, 20'h0ABCD, 20'h54321, 8'hFF, 4'b0000, "R7", "R5");
    // Mixed group needs one subset-3 entry while none is free; release one now
    run_group(1'b1, 20'h01234, 20'h43210, 20'h11111, 8'hE4, 4'b1000, "R7", "R5");
    // Released entry is available; release another in the same cycle as the pop
    run_group(1'b1, 20'h01234, 20'h43210, 20'h11111, 8'hE4, 4'b1000, "R8", "R6");
    run_group(1'b1, 20'h0F0F0, 20'h0A5A5, 20'h22222, 8'hE4, 4'b0000, "R8", "R6");
    run_group(1'b1, 20'h0F0F0, 20'h0A5A5, 20'h22222, 8'hE4, 4'b0000, "R8", "R6");

    // Randomized groups
    for (int n = 0; n < 600; n++) begin
      int rng;
      rng = ($urandom % 3 == 0) ? 6 : 32;
      for (int i = 0; i < LANES; i++) begin
        sa[i*5 +: 5] = 5'($urandom % rng);
        sb[i*5 +: 5] = 5'($urandom % rng);
        da[i*5 +: 5] = 5'($urandom % rng);
      end
      if ($urandom % 4 == 0) begin
        one = 2'($urandom);
        sdv = {4{one}};
      end else begin
        sdv = 8'($urandom);
      end
      run_group(($urandom % 8) != 0, sa, sb, da, sdv, 4'($urandom), "R7", "R6");
    end

    run_group(1'b0, '0, '0, '0, '0, 4'b0000, "R7", "R5");
    run_group(1'b0, '0, '0, '0, '0, 4'b0000, "R7", "R5");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule